// File: doc/BRIEF.md
# Transition-Nudged Bit Clock Recovery

This block recovers bit timing from a stream of demodulated samples, one hard-decision sample per strobe. A phase counter measures time in eighths of a sample. It gains a fixed step on every strobe, and when it crosses the bit-window size it folds back and the block emits one recovered bit. That bit is the majority vote of the three newest samples, so the decision is taken near the end of each window, where the samples of one bit have settled.

Whenever the sample history shows a transition that holds for two samples in a row, the counter is moved by one unit. It moves forward if the transition falls in the early half of the window and back if it falls in the late half. This keeps bit edges near the middle of the counter range, which places the decision point at the window boundary. Each recovered bit also enters an eight-bit history. From the two newest entries the block derives an NRZI-decoded bit for a downstream frame layer.

Top module: `bit_clock_recovery`

## Requirements
- R1: While reset (`rstN` low) is applied, and until the first bit is produced, `bitValid`, `recBit`, `nrziBit` and `actualBits` are all 0 and the phase counter is 0.
- R2: Each strobe adds 8 units to the phase counter, and cycles without a strobe leave it unchanged. With the default 8 samples per bit the window is 64 units, so after reset, with no transitions, the first bit comes out on the 8th strobe.
- R3: Let w be the four newest samples, with the sample of the current strobe in bit 0. A transition is detected on a strobe when w[0] differs from w[2] and w[1] differs from w[3]. A change that lasts a single sample is never a transition.
- R4: On a strobe with a transition, the counter first gains 1 unit if its value is below half the window (32) and loses 1 unit otherwise. The step of R2 is then added.
- R5: When the counter reaches or passes the window size, it is reduced by the window size and one bit is produced. The counter therefore always stays in the range 0 to window minus 1.
- R6: The recovered bit `recBit` is 1 when at least two of the three newest samples, counting the current one, are 1.
- R7: Each recovered bit is shifted into `actualBits` at bit 0, and older bits move toward the MSB. `actualBits` does not change on cycles without a produced bit.
- R8: `nrziBit` is 1 when the two newest bits of `actualBits` are equal and 0 when they differ.
- R9: `bitValid` is high for exactly the one cycle after the clock edge that takes in the wrapping strobe. `recBit`, `nrziBit` and `actualBits` are updated at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStrobe | input | 1 | One demodulated sample is present this cycle |
| sampleBit | input | 1 | Demodulated sample value |
| bitValid | output | 1 | A recovered bit is presented this cycle |
| recBit | output | 1 | Recovered bit (majority of three samples) |
| nrziBit | output | 1 | NRZI-decoded bit |
| actualBits | output | ACT_W | History of recovered bits, newest in bit 0 |

## Verification
The bench uses the default parameters: 8 samples per bit, a step of 8, a nudge of 1 and an 8-bit history. The window is therefore 64 units with its midpoint at 32. At this size, a few hundred samples are enough to drive the counter through many wraps. Bit streams with runs of 7, 8 and 9 samples put transitions in both halves of the window, so both nudge directions and a drifting bit boundary are covered within a short run. Single-sample glitches, gaps between strobes and a reset in the middle of a stream complete the stimulus. Every produced bit is compared in value and in exact cycle against a model that the bench computes from the requirements.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  // Strobes from the phase control to the datapath.
  typedef struct packed {
    logic sample;  // a sample is taken this cycle
    logic wrap;    // the phase counter crosses the window on this sample
  } bcrStrobes_t;
endpackage

// File: rtl/bcr_phase_ctrl.sv
module bcr_phase_ctrl
  import bcr_pkg::*;
#(
  parameter int SPB   = 8,
  parameter int STEP  = 8,
  parameter int NUDGE = 1,
  parameter int PW    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleStrobe,
  input  logic                 transition,
  output bcrStrobes_t          strobes,
  output logic signed [PW-1:0] phase
);
  localparam int WINDOW = SPB * STEP;
  localparam int HALF   = WINDOW / 2;
  localparam logic signed [PW-1:0] winS   = PW'(WINDOW);
  localparam logic signed [PW-1:0] halfS  = PW'(HALF);
  localparam logic signed [PW-1:0] stepS  = PW'(STEP);
  localparam logic signed [PW-1:0] nudgeS = PW'(NUDGE);

  logic signed [PW-1:0] nudged;
  logic signed [PW-1:0] advanced;
  logic signed [PW-1:0] phaseNext;
  logic                 early;
  logic                 crossed;

  always_comb begin
    early  = phase < halfS;
    nudged = phase;
    if (transition) begin
      nudged = early ? phase + nudgeS : phase - nudgeS;
    end
    advanced  = nudged + stepS;
    crossed   = advanced >= winS;
    phaseNext = crossed ? advanced - winS : advanced;
    strobes.sample = sampleStrobe;
    strobes.wrap   = sampleStrobe & crossed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (sampleStrobe) begin
      phase <= phaseNext;
    end
  end
endmodule

// File: rtl/bcr_datapath.sv
module bcr_datapath
  import bcr_pkg::*;
#(
  parameter int ACT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleBit,
  input  bcrStrobes_t      strobes,
  output logic             transition,
  output logic             bitValid,
  output logic             recBit,
  output logic             nrziBit,
  output logic [ACT_W-1:0] actualBits
);
  logic [2:0]       history;
  logic [3:0]       window;
  logic             vote;
  logic [ACT_W-1:0] actualNext;

  always_comb begin
    window     = {history, sampleBit};
    transition = ((window ^ (window >> 2)) & 4'b0011) == 4'b0011;
    vote       = (window[0] & window[1]) | (window[0] & window[2]) | (window[1] & window[2]);
    actualNext = {actualBits[ACT_W-2:0], vote};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      history    <= '0;
      bitValid   <= 1'b0;
      recBit     <= 1'b0;
      nrziBit    <= 1'b0;
      actualBits <= '0;
    end else begin
      bitValid <= strobes.wrap;
      if (strobes.sample) begin
        history <= window[2:0];
      end
      if (strobes.wrap) begin
        recBit     <= vote;
        actualBits <= actualNext;
        nrziBit    <= actualNext[0] == actualNext[1];
      end
    end
  end
endmodule

// File: rtl/bit_clock_recovery.sv
module bit_clock_recovery
  import bcr_pkg::*;
#(
  parameter int SPB   = 8,
  parameter int STEP  = 8,
  parameter int NUDGE = 1,
  parameter int PW    = 16,
  parameter int ACT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStrobe,
  input  logic             sampleBit,
  output logic             bitValid,
  output logic             recBit,
  output logic             nrziBit,
  output logic [ACT_W-1:0] actualBits
);
  bcrStrobes_t          strobes;
  logic                 transition;
  logic signed [PW-1:0] phase;

  bcr_phase_ctrl #(.SPB(SPB), .STEP(STEP), .NUDGE(NUDGE), .PW(PW)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .transition(transition),
    .strobes(strobes), .phase(phase)
  );

  bcr_datapath #(.ACT_W(ACT_W)) u_dp (
    .clk(clk), .rstN(rstN), .sampleBit(sampleBit), .strobes(strobes),
    .transition(transition), .bitValid(bitValid), .recBit(recBit),
    .nrziBit(nrziBit), .actualBits(actualBits)
  );
endmodule

// File: rtl/bit_clock_recovery_chk.sv
module bit_clock_recovery_chk
  import bcr_pkg::*;
#(
  parameter int SPB   = 8,
  parameter int STEP  = 8,
  parameter int NUDGE = 1,
  parameter int PW    = 16,
  parameter int ACT_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sampleStrobe,
  input logic                 bitValid,
  input logic                 recBit,
  input logic [ACT_W-1:0]     actualBits,
  input bcrStrobes_t          strobes,
  input logic signed [PW-1:0] phase
);
  localparam int WINDOW = SPB * STEP;

  p_phase_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase >= 0) && (int'(phase) < WINDOW));

  p_idle_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> $stable(phase));

  p_step_size_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && !strobes.wrap) |=>
      (int'(phase) - int'($past(phase)) >= STEP - NUDGE) &&
      (int'(phase) - int'($past(phase)) <= STEP + NUDGE));

  p_valid_follows_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrap |=> bitValid);

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  p_rec_in_history_r7: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (actualBits[0] == recBit));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrap |=> $stable(actualBits));
endmodule

bind bit_clock_recovery bit_clock_recovery_chk #(
  .SPB(SPB), .STEP(STEP), .NUDGE(NUDGE), .PW(PW), .ACT_W(ACT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .bitValid(bitValid),
  .recBit(recBit), .actualBits(actualBits), .strobes(strobes), .phase(phase)
);

// File: tb/test_bit_clock_recovery.sv
module test_bit_clock_recovery;
  localparam int ACT_W = 8;

  typedef struct {
    logic             bitv;
    logic             nrzi;
    logic [ACT_W-1:0] hist;
    int               due;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStrobe = 1'b0;
  logic sampleBit = 1'b0;
  logic bitValid, recBit, nrziBit;
  logic [ACT_W-1:0] actualBits;

  int testsRun = 0;
  int testsFailed = 0;
  int cycleCnt = 0;
  bit finished = 0;

  expItem_t expQ[$];
  int mPhase = 0;
  logic [3:0] mWin = '0;
  logic [ACT_W-1:0] mHist = '0;
  logic [15:0] lfsr = 16'hACE1;

  bit_clock_recovery i_bit_clock_recovery (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .sampleBit(sampleBit),
    .bitValid(bitValid), .recBit(recBit), .nrziBit(nrziBit), .actualBits(actualBits)
  );

  always #5ns clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycleCnt);
    end
  endtask

  // Model step taken from the requirements (R2 R3 R4 R5 R6 R7 R8).
  task automatic modelSample(input logic b);
    int p;
    logic v;
    expItem_t e;
    mWin = {mWin[2:0], b};
    p = mPhase;
    if ((mWin[0] != mWin[2]) && (mWin[1] != mWin[3])) p = (mPhase < 32) ? p + 1 : p - 1;
    p = p + 8;
    if (p >= 64) begin
      p = p - 64;
      v = (int'(mWin[0]) + int'(mWin[1]) + int'(mWin[2])) >= 2;
      mHist = {mHist[ACT_W-2:0], v};
      e.bitv = v;
      e.nrzi = mHist[0] == mHist[1];
      e.hist = mHist;
      e.due  = cycleCnt + 1;
      expQ.push_back(e);
    end
    mPhase = p;
  endtask

  task automatic sendSample(input logic b);
    @(negedge clk);
    sampleStrobe = 1'b1;
    sampleBit = b;
    modelSample(b);
  endtask

  // Idle cycles: the history must hold (R7).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleStrobe = 1'b0;
      sampleBit = ~sampleBit;
      check(actualBits == mHist, "R7 hold while idle", actualBits, mHist);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    sampleStrobe = 1'b0;
    expQ.delete();
    mPhase = 0;
    mWin = '0;
    mHist = '0;
    @(negedge clk);
    check(bitValid == 1'b0, "R1 bitValid in reset", bitValid, 0);
    check(actualBits == '0, "R1 actualBits in reset", actualBits, 0);
    check(recBit == 1'b0, "R1 recBit in reset", recBit, 0);
    check(nrziBit == 1'b0, "R1 nrziBit in reset", nrziBit, 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // NRZ bit stream with the given run length per bit.
  task automatic sendBits(input int nBits, input int runLen);
    for (int i = 0; i < nBits; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int k = 0; k < runLen; k++) sendSample(lfsr[0]);
    end
  endtask

  // Scoreboard monitor: value and exact cycle of every bit.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (expQ.size() > 0 && expQ[0].due == cycleCnt) begin
        expItem_t e;
        e = expQ.pop_front();
        check(bitValid == 1'b1, "R4 R5 R9 bit timing", bitValid, 1);
        check(recBit == e.bitv, "R6 recovered bit", recBit, e.bitv);
        check(actualBits == e.hist, "R7 bit history", actualBits, e.hist);
        check(nrziBit == e.nrzi, "R8 nrzi bit", nrziBit, e.nrzi);
      end else if (bitValid) begin
        check(1'b0, "R4 R5 R9 unexpected bit", 1, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog", cycleCnt, 150000);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    applyReset();
    // R2: constant input, first bit on the 8th strobe.
    for (int i = 0; i < 24; i++) sendSample(1'b1);
    idle(3);
    // Clean 8-sample bits, with a 3-sample offset.
    for (int i = 0; i < 3; i++) sendSample(1'b0);
    sendBits(40, 8);
    // Slow and fast senders: both nudge directions (R4).
    sendBits(40, 9);
    sendBits(40, 7);
    // R3: single-sample glitches are not transitions.
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 11; i++) sendSample(i == 5);
    end
    // Gaps between strobes (R2 R7).
    for (int i = 0; i < 30; i++) begin
      sendSample(i[3]);
      idle(i % 3);
    end
    // Mid-stream reset clears the phase (R1 R2).
    applyReset();
    for (int i = 0; i < 8; i++) sendSample(1'b0);
    sendBits(20, 8);
    idle(4);
    check(expQ.size() == 0, "R9 all bits produced", expQ.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule